// File: doc/BRIEF.md
# Serial Fuse Programming Sequencer

This block burns one word into a one-time-programmable fuse array, one bit at a time. A register front end hands it a word address, a 32-bit program word and a packed timing value, and pulses `start`. The sequencer first reads the fuse word already stored at that address. It then clears from the program word every bit that is already blown, so no fuse is ever struck twice.

The masked word sits in a visible data register. That register shifts right with zero fill as each bit is handled. A 1 in bit 0 earns a relax gap followed by a program strobe on that bit position. A 0 costs a single cycle. When all bits are handled, busy drops and done pulses. The block then holds off any new operation for a fixed postamble before it shows ready again.

States: IDLE, RD_RELAX, RD_PULSE, BIT_EVAL, PG_RELAX, PG_PULSE, DONE, POST. Transitions:
- IDLE→RD_RELAX on an accepted start.
- RD_RELAX→RD_PULSE when the relax count ends.
- RD_PULSE→BIT_EVAL when the read count ends, with the masked word loaded.
- BIT_EVAL→PG_RELAX when bit 0 is 1.
- BIT_EVAL→BIT_EVAL or DONE when bit 0 is 0, with a shift.
- PG_RELAX→PG_PULSE when the relax count ends.
- PG_PULSE→BIT_EVAL or DONE when the pulse count ends, with a shift.
- DONE→POST unconditionally.
- POST→IDLE when the postamble count ends.

Top module: `fuse_prog_seq`

## Requirements
- R1: After reset `busy`, `done`, `fuse_rd_en` and `fuse_pgm` are 0, `ready` is 1 and `shift_data` is 0.
- R2: The timing word packs the read width in bits [21:16], the relax count in bits [15:12] and the program width in bits [11:0]. After `start` is taken, `fuse_rd_en` stays low for the relax count of cycles. It is then high for exactly the read width of cycles, with `fuse_addr` equal to the requested address.
- R3: At `start`, `shift_data` takes the raw program word. In the first cycle after the read strobe ends, it holds program word AND NOT the fuse word read back.
- R4: Each 1 bit of the masked word produces one `fuse_pgm` pulse of exactly the program width in cycles. `fuse_bit` equals that bit's position. Pulses come in ascending bit order, and the read and program strobes are never high together.
- R5: A 0 bit takes one cycle. A 1 bit takes one cycle plus the relax count plus the program width. Busy therefore lasts relax + read width + 32 + ones × (relax + program width) cycles.
- R6: Each handled bit shifts `shift_data` right by one place with a 0 entering at the top. The register is 0 when busy falls.
- R7: `busy` falls in the cycle after the last bit is handled. In that same cycle `done` is high for exactly one cycle, and `busy` and `done` are never high together.
- R8: After `done`, `ready` stays low for exactly `POST_CYCLES` further cycles and then rises.
- R9: A `start` while `ready` is 0 is ignored: it changes neither the address, the data being burned, nor the timing of the run in progress.
- R10: A zero relax, read or program field is taken as one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a programming run (taken only when ready) |
| word_addr | input | ADDR_W | Fuse word address |
| prog_word | input | DATA_W | Bits to program (1 = blow) |
| timing_cfg | input | 22 | Packed read width, relax count, program width |
| fuse_rdata | input | DATA_W | Current fuse word at `fuse_addr` |
| fuse_addr | output | ADDR_W | Latched fuse word address |
| fuse_bit | output | $clog2(DATA_W) | Bit select for the program strobe |
| fuse_rd_en | output | 1 | Fuse read strobe |
| fuse_pgm | output | 1 | Fuse program strobe |
| shift_data | output | DATA_W | Visible data register |
| busy | output | 1 | Word being read or programmed |
| done | output | 1 | One-cycle completion pulse |
| ready | output | 1 | Idle and postamble elapsed |

## Verification
The bench builds the block with `DATA_W` 32, `ADDR_W` 6 and `POST_CYCLES` set to 12 instead of the 200-cycle default. This makes the exact postamble boundary cheap to count, and lets several full runs, plus starts injected during the quiet period, fit in a short bench. Timing words use small relax, read and program counts, including all-zero fields. This brings the exact cycle totals of every phase within reach, along with the rule that a zero field counts as one cycle.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;
    localparam int TIMING_W  = 22;
    localparam int TPROG_LSB = 0;
    localparam int TPROG_W   = 12;
    localparam int TRLX_LSB  = 12;
    localparam int TRLX_W    = 4;
    localparam int TRD_LSB   = 16;
    localparam int TRD_W     = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_RELAX,
        ST_RD_PULSE,
        ST_BIT_EVAL,
        ST_PG_RELAX,
        ST_PG_PULSE,
        ST_DONE,
        ST_POST
    } seq_state_t;

    typedef struct packed {
        logic [TRD_W-1:0]   rd_width;
        logic [TRLX_W-1:0]  relax;
        logic [TPROG_W-1:0] pg_width;
    } timing_t;
endpackage

// File: rtl/fuse_phase_timer.sv
module fuse_phase_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            // a zero length still occupies one cycle
            cnt <= (len == '0) ? '0 : len - CNT_W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign last = (cnt == '0);

    AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt == '0) |=> (cnt == '0)); // R10
endmodule

// File: rtl/fuse_data_shreg.sv
module fuse_data_shreg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_raw,
    input  logic [DATA_W-1:0] raw_word,
    input  logic              load_mask,
    input  logic [DATA_W-1:0] fuse_word,
    input  logic              shift,
    output logic [DATA_W-1:0] data,
    output logic              cur_bit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
        end else if (load_raw) begin
            data <= raw_word;
        end else if (load_mask) begin
            data <= data & ~fuse_word;
        end else if (shift) begin
            data <= {1'b0, data[DATA_W-1:1]};
        end
    end

    assign cur_bit = data[0];

    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load_raw) |=> (data[DATA_W-1] == 1'b0)); // R6
endmodule

// File: rtl/fuse_seq_ctrl.sv
module fuse_seq_ctrl
    import fuse_seq_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 12,
    parameter int POST_CYCLES = 200,
    localparam int IDX_W      = $clog2(DATA_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  timing_t          tcfg,
    input  logic             timer_last,
    input  logic             cur_bit,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_len,
    output logic             load_raw,
    output logic             load_mask,
    output logic             shift,
    output logic [IDX_W-1:0] bit_idx,
    output logic             busy,
    output logic             done,
    output logic             ready,
    output logic             rd_en,
    output logic             pgm
);
    seq_state_t st, nx;
    logic       bit_last;

    assign bit_last = (bit_idx == IDX_W'(DATA_W - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nx;
    end

    // bit position counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        bit_idx <= '0;
        else if (load_raw) bit_idx <= '0;
        else if (shift)    bit_idx <= bit_idx + IDX_W'(1);
    end

    // next state and datapath controls
    always_comb begin
        nx         = st;
        timer_load = 1'b0;
        timer_len  = '0;
        load_raw   = 1'b0;
        load_mask  = 1'b0;
        shift      = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start) begin
                    nx         = ST_RD_RELAX;
                    timer_load = 1'b1;
                    timer_len  = CNT_W'(tcfg.relax);
                    load_raw   = 1'b1;
                end
            end
            ST_RD_RELAX: begin
                if (timer_last) begin
                    nx         = ST_RD_PULSE;
                    timer_load = 1'b1;
                    timer_len  = CNT_W'(tcfg.rd_width);
                end
            end
            ST_RD_PULSE: begin
                if (timer_last) begin
                    nx        = ST_BIT_EVAL;
                    load_mask = 1'b1;
                end
            end
            ST_BIT_EVAL: begin
                if (cur_bit) begin
                    nx         = ST_PG_RELAX;
                    timer_load = 1'b1;
                    timer_len  = CNT_W'(tcfg.relax);
                end else begin
                    shift = 1'b1;
                    if (bit_last) nx = ST_DONE;
                end
            end
            ST_PG_RELAX: begin
                if (timer_last) begin
                    nx         = ST_PG_PULSE;
                    timer_load = 1'b1;
                    timer_len  = CNT_W'(tcfg.pg_width);
                end
            end
            ST_PG_PULSE: begin
                if (timer_last) begin
                    shift = 1'b1;
                    nx    = bit_last ? ST_DONE : ST_BIT_EVAL;
                end
            end
            ST_DONE: begin
                nx         = ST_POST;
                timer_load = 1'b1;
                timer_len  = CNT_W'(POST_CYCLES);
            end
            ST_POST: begin
                if (timer_last) nx = ST_IDLE;
            end
        endcase
    end

    // outputs decoded from state
    always_comb begin
        busy  = 1'b0;
        done  = 1'b0;
        ready = 1'b0;
        rd_en = 1'b0;
        pgm   = 1'b0;
        unique case (st)
            ST_IDLE:     ready = 1'b1;
            ST_RD_RELAX: busy  = 1'b1;
            ST_RD_PULSE: begin busy = 1'b1; rd_en = 1'b1; end
            ST_BIT_EVAL: busy  = 1'b1;
            ST_PG_RELAX: busy  = 1'b1;
            ST_PG_PULSE: begin busy = 1'b1; pgm = 1'b1; end
            ST_DONE:     done  = 1'b1;
            ST_POST:     ready = 1'b0;
        endcase
    end

    AST_PGM_ONLY_SET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PG_PULSE) |-> cur_bit); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy)); // R7
endmodule

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq
    import fuse_seq_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 6,
    parameter int POST_CYCLES = 200,
    localparam int IDX_W      = $clog2(DATA_W),
    localparam int POST_W     = $clog2(POST_CYCLES + 1),
    localparam int CNT_W      = (POST_W > TPROG_W) ? POST_W : TPROG_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   word_addr,
    input  logic [DATA_W-1:0]   prog_word,
    input  logic [TIMING_W-1:0] timing_cfg,
    input  logic [DATA_W-1:0]   fuse_rdata,
    output logic [ADDR_W-1:0]   fuse_addr,
    output logic [IDX_W-1:0]    fuse_bit,
    output logic                fuse_rd_en,
    output logic                fuse_pgm,
    output logic [DATA_W-1:0]   shift_data,
    output logic                busy,
    output logic                done,
    output logic                ready
);
    timing_t          tcfg_q;
    logic             timer_load, timer_last;
    logic [CNT_W-1:0] timer_len;
    logic             load_raw, load_mask, shift, cur_bit;

    // address and timing are captured once per accepted start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fuse_addr <= '0;
            tcfg_q    <= '0;
        end else if (load_raw) begin
            fuse_addr <= word_addr;
            tcfg_q    <= timing_t'(timing_cfg);
        end
    end

    fuse_seq_ctrl #(
        .DATA_W      (DATA_W),
        .CNT_W       (CNT_W),
        .POST_CYCLES (POST_CYCLES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .tcfg       (load_raw ? timing_t'(timing_cfg) : tcfg_q),
        .timer_last (timer_last),
        .cur_bit    (cur_bit),
        .timer_load (timer_load),
        .timer_len  (timer_len),
        .load_raw   (load_raw),
        .load_mask  (load_mask),
        .shift      (shift),
        .bit_idx    (fuse_bit),
        .busy       (busy),
        .done       (done),
        .ready      (ready),
        .rd_en      (fuse_rd_en),
        .pgm        (fuse_pgm)
    );

    fuse_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (timer_load),
        .len   (timer_len),
        .last  (timer_last)
    );

    fuse_data_shreg #(.DATA_W(DATA_W)) u_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_raw  (load_raw),
        .raw_word  (prog_word),
        .load_mask (load_mask),
        .fuse_word (fuse_rdata),
        .shift     (shift),
        .data      (shift_data),
        .cur_bit   (cur_bit)
    );

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fuse_rd_en && fuse_pgm)); // R4
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R7
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(fuse_addr)); // R9
endmodule

// File: tb/fuse_prog_seq_test.sv
module fuse_prog_seq_test;
    localparam int DW   = 32;
    localparam int AW   = 6;
    localparam int POST = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] word_addr = '0;
    logic [DW-1:0] prog_word = '0;
    logic [21:0]   timing_cfg = '0;
    logic [DW-1:0] fuse_rdata;
    logic [AW-1:0] fuse_addr;
    logic [4:0]    fuse_bit;
    logic          fuse_rd_en, fuse_pgm, busy, done, ready;
    logic [DW-1:0] shift_data;

    logic [DW-1:0] fmem [0:(1<<AW)-1];

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    fuse_prog_seq #(.DATA_W(DW), .ADDR_W(AW), .POST_CYCLES(POST)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .word_addr(word_addr),
        .prog_word(prog_word), .timing_cfg(timing_cfg), .fuse_rdata(fuse_rdata),
        .fuse_addr(fuse_addr), .fuse_bit(fuse_bit), .fuse_rd_en(fuse_rd_en),
        .fuse_pgm(fuse_pgm), .shift_data(shift_data), .busy(busy),
        .done(done), .ready(ready)
    );

    // behavioural fuse array
    assign fuse_rdata = fmem[fuse_addr];
    always @(posedge clk) begin
        if (fuse_pgm) fmem[fuse_addr][fuse_bit] <= 1'b1;
        cycles <= cycles + 1;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // one programming run; inject issues extra starts while not ready
    task automatic run_prog(input logic [AW-1:0] addr, input logic [DW-1:0] data,
                            input int r, input int s, input int p, input bit inject);
        logic [DW-1:0] old_w, masked, remain, prev_sd, other_w;
        int rr, ss, pp, ones, k, busy_n, rd_n, first_rd, pgm_n, done_n, post_n;
        int plen, exp_bit;
        bit prev_rd, prev_pgm, prev_busy, loaded, done_ok;
        rr = eff(r); ss = eff(s); pp = eff(p);
        old_w   = fmem[addr];
        other_w = fmem[addr ^ 6'h1];
        masked  = data & ~old_w;
        ones    = $countones(masked);
        remain  = masked;
        @(negedge clk);
        start      = 1'b1;
        word_addr  = addr;
        prog_word  = data;
        timing_cfg = {6'(s), 4'(r), 12'(p)};
        @(negedge clk);
        start = 1'b0;
        chk(shift_data == data, "R3 raw load", shift_data, data);
        k = 0; busy_n = 0; rd_n = 0; first_rd = 0; pgm_n = 0; done_n = 0; post_n = 0;
        plen = 0; prev_rd = 0; prev_pgm = 0; prev_busy = 1; loaded = 0; done_ok = 1;
        prev_sd = shift_data;
        while (!ready && k < 20000) begin
            k++;
            if (busy) busy_n++;
            if (fuse_rd_en) begin
                rd_n++;
                if (first_rd == 0) first_rd = k;
                if (fuse_addr != addr) chk(0, "R2 read addr", fuse_addr, addr);
            end
            if (prev_rd && !fuse_rd_en) begin
                chk(shift_data == masked, "R3 masked word", shift_data, masked);
                loaded = 1;
            end else if (loaded && shift_data != prev_sd && shift_data != (prev_sd >> 1)) begin
                chk(0, "R6 shift right zero fill", shift_data, prev_sd >> 1);
            end
            if (fuse_pgm) begin
                pgm_n++;
                plen++;
                if (!prev_pgm) begin
                    exp_bit = 0;
                    for (int b = DW-1; b >= 0; b--) if (remain[b]) exp_bit = b;
                    chk(fuse_bit == 5'(exp_bit), "R4 bit order", fuse_bit, exp_bit);
                    remain[exp_bit] = 1'b0;
                end
            end else if (prev_pgm) begin
                chk(plen == pp, "R4 pulse width", plen, pp);
                plen = 0;
            end
            if (done) begin
                done_n++;
                if (!prev_busy) done_ok = 0;
            end
            if (!busy && !done && !ready) post_n++;
            prev_rd = fuse_rd_en; prev_pgm = fuse_pgm; prev_busy = busy;
            prev_sd = shift_data;
            if (inject && (k == 3 || (!busy && !done))) begin
                start     = 1'b1;
                word_addr = addr ^ 6'h1;
                prog_word = 32'hFFFF_FFFF;
                timing_cfg = '0;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(first_rd == rr + 1, "R2 relax before read", first_rd, rr + 1);
        chk(rd_n == ss, "R2 read width", rd_n, ss);
        chk(pgm_n == ones * pp, "R4 program cycles", pgm_n, ones * pp);
        chk(busy_n == rr + ss + DW + ones * (rr + pp), "R5 busy length", busy_n,
            rr + ss + DW + ones * (rr + pp));
        chk(done_n == 1 && done_ok, "R7 single done after busy", done_n, 1);
        chk(post_n == POST, "R8 postamble length", post_n, POST);
        chk(shift_data == '0, "R6 drained to zero", shift_data, 0);
        chk(fmem[addr] == (old_w | data), "R4 fuse word", fmem[addr], old_w | data);
        chk(fuse_addr == addr, "R9 addr kept", fuse_addr, addr);
        chk(fmem[addr ^ 6'h1] == other_w, "R9 other word untouched",
            fmem[addr ^ 6'h1], other_w);
    endtask

    task automatic test_reset();
        chk(!busy && !done && ready && !fuse_rd_en && !fuse_pgm && shift_data == '0,
            "R1 reset state", {busy, done, ready, fuse_rd_en, fuse_pgm}, 5'b00100);
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) fmem[i] = '0;
        fmem[5] = 32'h0000_00F0;
        fmem[3] = 32'hFFFF_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_prog(6'd5, 32'h8000_01F3, 2, 3, 4, 1'b1); // R3 R4 R9 with injected starts
        run_prog(6'd7, 32'h0000_0000, 1, 2, 5, 1'b0); // R5 all-zero word
        run_prog(6'd9, 32'h0000_0005, 0, 0, 0, 1'b0); // R10 zero fields
        run_prog(6'd3, 32'hFFFF_0000, 3, 1, 2, 1'b1); // R3 fully pre-blown
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule